// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest access to an I/O port has to leave the guest. A permission bitmap in memory holds one bit per port. A port number, the bitmap base address, a packed access-info word and the current instruction pointer with its increment arrive on a valid/ready request interface. The block then fetches the bitmap bits for every port the access covers and reports whether an exit is needed. On an exit it also forms the exit code and two exit information words.

The size of the access in bytes sits in the access-info word. An access of several bytes touches several consecutive ports. Their bits may lie across a byte boundary of the bitmap, so the checker always fetches two consecutive bytes and joins them into a 16-bit window. The whole check is gated by an I/O intercept enable input. When that input is low, the request completes at once with no memory traffic and no exit.

Back-pressure rules are as follows. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after `done`. A memory read request holds its address while `mem_req_ready` is low. A read response is taken on a cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high. `done` and the exit outputs are plain one-cycle status outputs with no handshake.

Top module: `io_perm_checker`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low up to and including the cycle in which `done` is high. After reset `req_ready` is high.
- R2: If `io_intercept` is low at acceptance, no memory read request is issued. `done` rises in the cycle after acceptance, with `exit_valid` low.
- R3: With the intercept enabled, exactly two byte reads are issued, in order. The first is at `bitmap_base + port_num[15:3]` and gives the low byte of the window. The second is at the next address and gives the high byte.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address stays unchanged.
- R5: The access size is `access_info[6:4]`. The check mask is `((1 << size) - 1) << port_num[2:0]` over the 16-bit window, and an exit is signalled when any bit of the window under the mask is set. This includes bits that fall in the second byte.
- R6: A size of 0 never produces an exit, even when every bitmap bit is set.
- R7: `done` is high for exactly one cycle. It comes in the cycle after the second read response is taken, and `exit_valid` is only high together with `done`.
- R8: On an exit, `exit_code` equals the parameter `EXIT_IO` (default 0x7B).
- R9: On an exit, `exit_info1` equals `access_info | (port_num << 16)`, in 32 bits.
- R10: On an exit, `exit_info2` equals `cur_ip + ip_incr`, in `IP_W` bits.
- R11: After reset, `done`, `exit_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_intercept | input | 1 | I/O intercept enable, sampled at request acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| bitmap_base | input | ADDR_W | Byte address of the permission bitmap |
| port_num | input | 16 | I/O port number |
| access_info | input | 32 | Packed access info; size in bits [6:4] |
| cur_ip | input | IP_W | Current instruction pointer |
| ip_incr | input | INC_W | Length of the current instruction |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Byte read request ready |
| mem_req_addr | output | ADDR_W | Byte read address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Read response ready |
| mem_rsp_data | input | 8 | Read response byte |
| done | output | 1 | One-cycle completion pulse |
| exit_valid | output | 1 | Exit required (only with done) |
| exit_code | output | CODE_W | Exit code for I/O |
| exit_info1 | output | 32 | Access info with the port in the upper half |
| exit_info2 | output | IP_W | Address of the next instruction |

## Verification
With the intercept disabled, `done` is due exactly one cycle after the acceptance edge. With it enabled, `done` is due one cycle after the edge on which the second read response is taken, and the exit verdict and all exit fields are due in that same cycle. The bench memory applies random request back-pressure and response latency. A reference model updated on every rising edge predicts from the handshakes whether `done` must be high in the following cycle. Each falling edge then compares `done`, `exit_valid` and the exit fields against that prediction. After each transaction, the logged read addresses are compared with the two expected bitmap bytes, or with none when the intercept is disabled.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_FIN
  } fetch_st_e;

  localparam int WIN_W = 16;

  function automatic logic [WIN_W-1:0] span_mask(input logic [2:0] sz, input logic [2:0] off);
    logic [WIN_W-1:0] base_m;
    base_m = (WIN_W'(1) << sz) - WIN_W'(1);
    return base_m << off;
  endfunction

endpackage

// File: rtl/io_perm_mask.sv
module io_perm_mask
  import io_perm_pkg::*;
(
  input  logic [2:0]       size_fld,
  input  logic [2:0]       bit_off,
  input  logic [WIN_W-1:0] window,
  output logic             hit
);

  logic [WIN_W-1:0] mask;
  logic [WIN_W-1:0] sel;

  assign mask = span_mask(size_fld, bit_off);

  for (genvar g = 0; g < WIN_W; g++) begin : g_sel
    assign sel[g] = window[g] & mask[g];
  end

  assign hit = |sel;

endmodule

// File: rtl/io_perm_fetch.sv
module io_perm_fetch
  import io_perm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  output logic [WIN_W-1:0]  window,
  output logic              fin
);

  fetch_st_e         st;
  logic              idx;
  logic [7:0]        lo_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WIN_W-1:0]  win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      idx    <= 1'b0;
      lo_q   <= '0;
      addr_q <= '0;
      win_q  <= '0;
    end else begin
      case (st)
        F_IDLE: begin
          if (start) begin
            idx    <= 1'b0;
            addr_q <= start_addr;
            st     <= F_REQ;
          end
        end
        F_REQ: begin
          if (mem_req_ready) st <= F_WAIT;
        end
        F_WAIT: begin
          if (mem_rsp_valid) begin
            if (!idx) begin
              lo_q <= mem_rsp_data;
              idx  <= 1'b1;
              st   <= F_REQ;
            end else begin
              win_q <= {mem_rsp_data, lo_q};
              st    <= F_FIN;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == F_REQ);
  assign mem_req_addr  = addr_q + ADDR_W'(idx);
  assign mem_rsp_ready = (st == F_WAIT);
  assign window        = win_q;
  assign fin           = (st == F_FIN);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fin_after_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready && idx) |=> fin);

  assert_rsp_not_while_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

endmodule

// File: rtl/io_perm_format.sv
module io_perm_format #(
  parameter int                 IP_W    = 64,
  parameter int                 INC_W   = 4,
  parameter int                 CODE_W  = 16,
  parameter logic [CODE_W-1:0]  EXIT_IO = 'h7B
) (
  input  logic [15:0]       port_num,
  input  logic [31:0]       acc_info,
  input  logic [IP_W-1:0]   ip,
  input  logic [INC_W-1:0]  incr,
  output logic [CODE_W-1:0] code,
  output logic [31:0]       info1,
  output logic [IP_W-1:0]   info2
);

  assign code  = EXIT_IO;
  assign info1 = acc_info | {port_num, 16'h0000};
  assign info2 = ip + IP_W'(incr);

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
  import io_perm_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                IP_W    = 64,
  parameter int                INC_W   = 4,
  parameter int                CODE_W  = 16,
  parameter logic [CODE_W-1:0] EXIT_IO = 'h7B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_intercept,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] bitmap_base,
  input  logic [15:0]       port_num,
  input  logic [31:0]       access_info,
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [INC_W-1:0]  ip_incr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  output logic              done,
  output logic              exit_valid,
  output logic [CODE_W-1:0] exit_code,
  output logic [31:0]       exit_info1,
  output logic [IP_W-1:0]   exit_info2
);

  localparam int BYTE_IDX_W = 16 - 3;

  logic              busy;
  logic              byp_fin;
  logic              accept;
  logic              fin;
  logic              hit;
  logic [15:0]       port_q;
  logic [31:0]       info_q;
  logic [IP_W-1:0]   ip_q;
  logic [INC_W-1:0]  inc_q;
  logic [WIN_W-1:0]  window;
  logic [ADDR_W-1:0] byte_addr;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign byte_addr = bitmap_base + ADDR_W'(port_num[15 -: BYTE_IDX_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      byp_fin <= 1'b0;
      port_q  <= '0;
      info_q  <= '0;
      ip_q    <= '0;
      inc_q   <= '0;
    end else begin
      byp_fin <= accept && !io_intercept;
      if (accept) begin
        busy   <= 1'b1;
        port_q <= port_num;
        info_q <= access_info;
        ip_q   <= cur_ip;
        inc_q  <= ip_incr;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  io_perm_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept && io_intercept),
    .start_addr   (byte_addr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data (mem_rsp_data),
    .window       (window),
    .fin          (fin)
  );

  io_perm_mask u_mask (
    .size_fld(info_q[6:4]),
    .bit_off (port_q[2:0]),
    .window  (window),
    .hit     (hit)
  );

  io_perm_format #(
    .IP_W   (IP_W),
    .INC_W  (INC_W),
    .CODE_W (CODE_W),
    .EXIT_IO(EXIT_IO)
  ) u_format (
    .port_num(port_q),
    .acc_info(info_q),
    .ip      (ip_q),
    .incr    (inc_q),
    .code    (exit_code),
    .info1   (exit_info1),
    .info2   (exit_info2)
  );

  assign done       = fin || byp_fin;
  assign exit_valid = fin && hit;

  assert_accept_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !io_intercept) |=> (done && !exit_valid && !mem_req_valid));

  assert_exit_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_size0_no_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && info_q[6:4] == 3'd0) |-> !exit_valid);

endmodule

// File: tb/test_io_perm_checker.sv
module test_io_perm_checker;

  localparam int ADDR_W = 32;
  localparam int IP_W   = 64;
  localparam int INC_W  = 4;
  localparam int CODE_W = 16;
  localparam logic [CODE_W-1:0] EXIT_IO = 16'h007B;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              io_intercept = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] bitmap_base = '0;
  logic [15:0]       port_num = '0;
  logic [31:0]       access_info = '0;
  logic [IP_W-1:0]   cur_ip = '0;
  logic [INC_W-1:0]  ip_incr = '0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_ready;
  logic [7:0]        mem_rsp_data = '0;
  logic              done;
  logic              exit_valid;
  logic [CODE_W-1:0] exit_code;
  logic [31:0]       exit_info1;
  logic [IP_W-1:0]   exit_info2;

  always #10 clk = ~clk;

  io_perm_checker #(
    .ADDR_W(ADDR_W), .IP_W(IP_W), .INC_W(INC_W), .CODE_W(CODE_W), .EXIT_IO(EXIT_IO)
  ) i_io_perm_checker (
    .clk(clk), .rst_n(rst_n), .io_intercept(io_intercept),
    .req_valid(req_valid), .req_ready(req_ready), .bitmap_base(bitmap_base),
    .port_num(port_num), .access_info(access_info), .cur_ip(cur_ip), .ip_incr(ip_incr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done(done), .exit_valid(exit_valid), .exit_code(exit_code),
    .exit_info1(exit_info1), .exit_info2(exit_info2)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] bmem [int unsigned];
  logic [ADDR_W-1:0] rd_log [$];

  function automatic logic [7:0] rd_byte(input logic [ADDR_W-1:0] a);
    if (bmem.exists(a)) return bmem[a];
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference model state
  logic            exp_done = 1'b0;
  logic            exp_hit  = 1'b0;
  logic [31:0]     exp_info1;
  logic [IP_W-1:0] exp_info2;
  int              rsp_cnt = 0;
  logic            pend = 1'b0;
  logic [1:0]      lat_cnt = '0;
  logic [ADDR_W-1:0] pend_addr = '0;
  logic [7:0]      lfsr = 8'hA7;
  bit              started = 1'b0;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_done      <= 1'b0;
      rsp_cnt       <= 0;
      pend          <= 1'b0;
      mem_rsp_valid <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        rsp_cnt  <= 0;
        exp_done <= !io_intercept;
      end else begin
        exp_done <= mem_rsp_valid && mem_rsp_ready && (rsp_cnt == 1);
      end
      if (mem_rsp_valid && mem_rsp_ready) begin
        rsp_cnt       <= rsp_cnt + 1;
        mem_rsp_valid <= 1'b0;
        pend          <= 1'b0;
      end
      if (!pend && mem_req_valid && mem_req_ready) begin
        pend      <= 1'b1;
        lat_cnt   <= lfsr[2:1];
        pend_addr <= mem_req_addr;
        rd_log.push_back(mem_req_addr);
      end else if (pend && !mem_rsp_valid) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd_byte(pend_addr);
        end else begin
          lat_cnt <= lat_cnt - 2'd1;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (started) begin
      if (done || exp_done)
        check(done == exp_done, "R7 done timing", 64'(done), 64'(exp_done));
      if (done && exp_done) begin
        check(exit_valid == exp_hit, "R5 exit verdict", 64'(exit_valid), 64'(exp_hit));
        if (exp_hit && exit_valid) begin
          check(exit_code == EXIT_IO, "R8 exit code", 64'(exit_code), 64'(EXIT_IO));
          check(exit_info1 == exp_info1, "R9 exit info1", 64'(exit_info1), 64'(exp_info1));
          check(exit_info2 == exp_info2, "R10 exit info2", exit_info2, exp_info2);
        end
      end
    end
  end

  task automatic access(input bit icpt, input logic [ADDR_W-1:0] base, input logic [15:0] port,
                        input logic [31:0] info, input logic [IP_W-1:0] ip, input logic [INC_W-1:0] inc);
    logic [ADDR_W-1:0] a0;
    logic [15:0] word;
    logic [15:0] mask;
    a0        = base + ADDR_W'(port >> 3);
    word      = {rd_byte(a0 + 1), rd_byte(a0)};
    mask      = ((16'd1 << info[6:4]) - 16'd1) << port[2:0];
    exp_hit   = icpt && ((word & mask) != 16'd0);
    exp_info1 = info | {port, 16'h0000};
    exp_info2 = ip + IP_W'(inc);
    rd_log.delete();
    @(negedge clk);
    io_intercept = icpt; bitmap_base = base; port_num = port;
    access_info = info; cur_ip = ip; ip_incr = inc; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 ready low after accept", 64'(req_ready), 64'd0);
    while (!done) @(negedge clk);
    check(req_ready == 1'b0, "R1 ready low in done cycle", 64'(req_ready), 64'd0);
    if (!icpt) begin
      check(rd_log.size() == 0, "R2 no read when intercept clear", 64'(rd_log.size()), 64'd0);
      check(exit_valid == 1'b0, "R2 no exit when intercept clear", 64'(exit_valid), 64'd0);
    end else begin
      check(rd_log.size() == 2, "R3 read count", 64'(rd_log.size()), 64'd2);
      if (rd_log.size() == 2) begin
        check(rd_log[0] == a0, "R3 first read address", 64'(rd_log[0]), 64'(a0));
        check(rd_log[1] == a0 + 1, "R3 second read address", 64'(rd_log[1]), 64'(a0 + 1));
      end
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready restored", 64'(req_ready), 64'd1);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  localparam logic [ADDR_W-1:0] BASE = 32'h0001_0000;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(done == 1'b0, "R11 done in reset", 64'(done), 64'd0);
    check(exit_valid == 1'b0, "R11 exit_valid in reset", 64'(exit_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R11 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    started = 1'b1;

    // R2: intercept clear, bit set
    bmem[BASE + 32'h8] = 8'hFF;
    access(1'b0, BASE, 16'h0040, 32'h10, 64'h1000, 4'd2);
    // R5 hit, single byte
    bmem[BASE + 32'h8] = 8'h01;
    access(1'b1, BASE, 16'h0040, 32'h10, 64'hFFFF_FFFF_FFFF_FFFE, 4'd3);
    // R5 miss on neighbour port
    access(1'b1, BASE, 16'h0041, 32'h10, 64'h2000, 4'd1);
    // R5 straddle: size 2 at bit 7, set bit in next byte
    bmem[BASE + 32'h20] = 8'h00;
    bmem[BASE + 32'h21] = 8'h01;
    access(1'b1, BASE, 16'h0107, 32'h20, 64'h3000, 4'd2);
    // R5 straddle: size 4 at bit 6
    bmem[BASE + 32'h41] = 8'h02;
    access(1'b1, BASE, 16'h0206, 32'h40, 64'h4000, 4'd5);
    // R6 size 0 on all-ones
    bmem[BASE + 32'h50] = 8'hFF;
    bmem[BASE + 32'h51] = 8'hFF;
    access(1'b1, BASE, 16'h0283, 32'h0000_0300, 64'h5000, 4'd1);
    // R3 top of port space
    bmem[BASE + 32'h1FFF] = 8'h80;
    access(1'b1, BASE, 16'hFFFF, 32'h10, 64'h6000, 4'd1);
    // R5 size 7 at bit 7: top bit of mask is bit 13
    bmem[BASE + 32'h61] = 8'h20;
    access(1'b1, BASE, 16'h0307, 32'h70, 64'h7000, 4'd4);
    bmem[BASE + 32'h61] = 8'h40;
    access(1'b1, BASE, 16'h0307, 32'h70, 64'h7000, 4'd4);
    // R9 upper bits of info ORed with port
    bmem[BASE + 32'h80] = 8'h10;
    access(1'b1, BASE, 16'h0404, 32'h00C3_0012, 64'h8000, 4'd6);

    // mixed patterns
    for (int k = 0; k < 40; k++) begin
      logic [15:0] p;
      logic [ADDR_W-1:0] a;
      p = 16'($urandom_range(0, 65535));
      a = BASE + ADDR_W'(p >> 3);
      bmem[a]     = 8'($urandom_range(0, 255)) & 8'($urandom_range(0, 255));
      bmem[a + 1] = 8'($urandom_range(0, 255)) & 8'($urandom_range(0, 255));
      access(($urandom_range(0, 3) != 0), BASE, p,
             32'($urandom_range(0, 7)) << 4 | 32'($urandom_range(0, 15)),
             {32'($urandom), 32'($urandom)}, 4'($urandom_range(1, 15)));
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule